// File: doc/BRIEF.md
# DDC EDID Read Engine

This block fetches one 128-byte EDID block from a display over the two-wire DDC bus and keeps it in an on-chip receive FIFO. A host reaches it through a small byte-wide register port. For each fetch the host writes a FIFO start slot, then the word offset, and last the segment number. The write of the segment number starts the engine. The engine runs the enhanced-DDC read sequence on its open-drain SCL and SDA outputs. It stores every received byte, then reports completion, and a failure if there was one, through a write-one-to-clear status register and a maskable interrupt.

On the bus the sequence has three parts. The first is a segment-pointer write to device 0x60, which is left out when the segment is 0. The second writes the word offset to device 0xA0. The third is a read through device 0xA1, which takes 128 bytes. A repeated START separates the phases. The master ACKs every byte except the last, which it NACKs, and a STOP follows. If any address or data byte the engine sends is not acknowledged, the engine sends STOP at once and flags an error. The SCL rate comes from a 16-bit divider: every bit lasts four divider periods.

Top module: `ddc_edid_reader`

## Requirements
- R1: After reset, both bus outputs are released (`sclDrvLow`=0, `sdaDrvLow`=0), `irq` is 0, and every register reads 0. The register offsets are: 0 divider low byte, 1 divider high byte, 2 FIFO start slot (7 bits), 3 word offset, 4 segment, 5 interrupt mask (bit 0), 6 status (bit 0 done, bit 1 error), 7 FIFO data.
- R2: When the engine is idle, a write to offset 4 starts a transfer. SDA changes while SCL is released only inside START, repeated START and STOP conditions.
- R3: A segment value of 0 leaves out the device-0x60 phase entirely. A non-zero segment is sent to device 0x60 before the offset phase.
- R4: The read phase receives exactly 128 bytes. It ACKs bytes 1 to 127, NACKs the 128th, and then sends STOP.
- R5: Received byte i (counting from 0) is stored in FIFO slot (start slot + i) mod 128.
- R6: At the end of a transfer, status bit 0 (done) is set. `irq` is high exactly while done is set and mask bit 0 is 1.
- R7: Writing 1 to a status bit clears that bit. Writing 0 leaves it unchanged.
- R8: One SCL period lasts 4×D clock cycles, where D is the 16-bit divider value. A divider value of 0 acts as 1.
- R9: While a transfer is running, writes to offsets 0 to 4 are ignored. A write to the segment register during a transfer neither changes it nor starts another transfer.
- R10: Each transfer resets the FIFO read pointer to slot 0. Only a read of offset 7 advances the pointer, by one slot, wrapping modulo 128. Reads of other offsets leave it in place.
- R11: A missing ACK on any byte the engine sends sets status bits 0 and 1, sends STOP, and leaves both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (pops the FIFO at offset 7) |
| regAddr | input | 3 | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, valid in the cycle of the read |
| irq | output | 1 | Completion interrupt, masked |
| sclDrvLow | output | 1 | Pull SCL low when 1, release when 0 |
| sdaDrvLow | output | 1 | Pull SDA low when 1, release when 0 |
| sdaIn | input | 1 | Sampled SDA line level |

## Verification
The bench attaches a display model that answers at 0x60, 0xA0 and 0xA1, and can refuse the segment address. It targets four corner cases. The first is segment 0: a design that still sent the 0x60 phase would be NACKed by the model and would report an error. The second is a non-zero FIFO start slot: a design that applied the offset to the read pointer as well would return the bytes in plain order instead of rotated. The third is the final read byte, where a missing NACK makes the model count a 129th byte. The fourth is a segment write arriving mid-transfer, which must neither restart the bus nor change the block fetched. SCL period is measured for divider values 0, 2 and 3.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  // register offsets on the host port
  localparam logic [2:0] A_DIVLO = 3'd0;
  localparam logic [2:0] A_DIVHI = 3'd1;
  localparam logic [2:0] A_START = 3'd2;
  localparam logic [2:0] A_OFF   = 3'd3;
  localparam logic [2:0] A_SEG   = 3'd4;
  localparam logic [2:0] A_MASK  = 3'd5;
  localparam logic [2:0] A_STAT  = 3'd6;
  localparam logic [2:0] A_DATA  = 3'd7;

  localparam logic [7:0] DEV_SEG = 8'h60;
  localparam logic [7:0] DEV_WR  = 8'hA0;
  localparam logic [7:0] DEV_RD  = 8'hA1;

  typedef enum logic [2:0] {
    STEP_SEGDEV, STEP_SEG, STEP_ADRDEV, STEP_OFF, STEP_RDDEV, STEP_DATA
  } stepE;

  typedef struct packed {
    logic initPtrs;
    logic loadTx;
    stepE txSel;
    logic shiftBit;
    logic pushByte;
    logic setDone;
    logic setErr;
  } ddcCtlS;

  function automatic stepE nextStep(stepE s);
    case (s)
      STEP_SEGDEV: return STEP_SEG;
      STEP_SEG:    return STEP_ADRDEV;
      STEP_ADRDEV: return STEP_OFF;
      STEP_OFF:    return STEP_RDDEV;
      default:     return STEP_DATA;
    endcase
  endfunction
endpackage

// File: rtl/ddc_datapath.sv
module ddc_datapath
  import ddc_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rstN,
  input  ddcCtlS      ctl,
  input  logic        busy,
  input  logic        sdaIn,
  input  logic        regWe,
  input  logic        regRe,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  output logic        irq,
  output logic        startReq,
  output logic        segZero,
  output logic        txMsb,
  output logic [15:0] divVal
);
  logic [7:0]    segReg, offReg, shiftReg;
  logic [AW-1:0] startReg, wrPtr, rdPtr;
  logic          maskReg, stDone, stErr;
  logic [7:0]    mem [DEPTH];
  logic          cfgWe;

  assign cfgWe    = regWe && !busy;
  assign startReq = cfgWe && (regAddr == A_SEG);
  assign segZero  = (segReg == 8'd0);
  assign txMsb    = shiftReg[7];
  assign irq      = stDone && maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divVal <= '0; segReg <= '0; offReg <= '0; startReg <= '0; maskReg <= 1'b0;
    end else begin
      if (cfgWe && regAddr == A_DIVLO) divVal[7:0]  <= regWdata;
      if (cfgWe && regAddr == A_DIVHI) divVal[15:8] <= regWdata;
      if (cfgWe && regAddr == A_START) startReg <= regWdata[AW-1:0];
      if (cfgWe && regAddr == A_OFF)   offReg <= regWdata;
      if (cfgWe && regAddr == A_SEG)   segReg <= regWdata;
      if (regWe && regAddr == A_MASK)  maskReg <= regWdata[0];
    end
  end

  // status: write-one-to-clear, hardware set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stDone <= 1'b0; stErr <= 1'b0;
    end else begin
      if (ctl.setDone) stDone <= 1'b1;
      else if (regWe && regAddr == A_STAT && regWdata[0]) stDone <= 1'b0;
      if (ctl.setErr) stErr <= 1'b1;
      else if (regWe && regAddr == A_STAT && regWdata[1]) stErr <= 1'b0;
    end
  end

  // shared transmit/receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (ctl.loadTx) begin
      case (ctl.txSel)
        STEP_SEGDEV: shiftReg <= DEV_SEG;
        STEP_SEG:    shiftReg <= segReg;
        STEP_ADRDEV: shiftReg <= DEV_WR;
        STEP_OFF:    shiftReg <= offReg;
        STEP_RDDEV:  shiftReg <= DEV_RD;
        default:     shiftReg <= '0;
      endcase
    end else if (ctl.shiftBit) shiftReg <= {shiftReg[6:0], sdaIn};
  end

  // receive FIFO
  always_ff @(posedge clk) begin
    if (ctl.pushByte) mem[wrPtr] <= shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0;
    end else begin
      if (ctl.initPtrs) wrPtr <= startReg;
      else if (ctl.pushByte) wrPtr <= wrPtr + 1'b1;
      if (ctl.initPtrs) rdPtr <= '0;
      else if (regRe && regAddr == A_DATA) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_comb begin
    case (regAddr)
      A_DIVLO: regRdata = divVal[7:0];
      A_DIVHI: regRdata = divVal[15:8];
      A_START: regRdata = 8'(startReg);
      A_OFF:   regRdata = offReg;
      A_SEG:   regRdata = segReg;
      A_MASK:  regRdata = {7'd0, maskReg};
      A_STAT:  regRdata = {6'd0, stErr, stDone};
      default: regRdata = mem[rdPtr];
    endcase
  end

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setDone |=> stDone);
  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_STAT && regWdata[0] && !ctl.setDone) |=> !stDone);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWe && regAddr == A_SEG) |=> $stable(segReg));
endmodule

// File: rtl/ddc_control.sv
module ddc_control
  import ddc_pkg::*;
#(
  parameter int BYTES = 128,
  localparam int BW = $clog2(BYTES)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        segZero,
  input  logic        txMsb,
  input  logic        sdaIn,
  input  logic [15:0] divVal,
  output ddcCtlS      ctl,
  output logic        busy,
  output logic        sclDrvLow,
  output logic        sdaDrvLow
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} stateE;
  localparam logic [BW-1:0] LAST = BW'(BYTES - 1);

  stateE       state;
  stepE        step;
  logic [1:0]  q;
  logic [3:0]  bitCnt;
  logic [BW-1:0] byteCnt;
  logic [15:0] divCnt, divMax;
  logic        tick, errFlag, ackSlot, isData;

  assign divMax  = (divVal == 16'd0) ? 16'd0 : divVal - 16'd1;
  assign tick    = (state != S_IDLE) && (divCnt == divMax);
  assign busy    = (state != S_IDLE);
  assign ackSlot = (bitCnt == 4'd8);
  assign isData  = (step == STEP_DATA);

  always_comb begin
    ctl = '0;
    ctl.txSel = step;
    if (state == S_IDLE && startReq) ctl.initPtrs = 1'b1;
    if (tick) begin
      case (state)
        S_START: if (q == 2'd3) begin
          ctl.loadTx = 1'b1;
          ctl.txSel  = (step == STEP_SEGDEV && segZero) ? STEP_ADRDEV : step;
        end
        S_BIT: begin
          if (q == 2'd2 && !ackSlot) ctl.shiftBit = 1'b1;
          if (q == 2'd0 && ackSlot && isData) ctl.pushByte = 1'b1;
          if (q == 2'd3 && ackSlot && !errFlag &&
              (step == STEP_SEGDEV || step == STEP_ADRDEV)) begin
            ctl.loadTx = 1'b1;
            ctl.txSel  = nextStep(step);
          end
        end
        S_STOP: if (q == 2'd3) begin
          ctl.setDone = 1'b1;
          ctl.setErr  = errFlag;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; step <= STEP_SEGDEV; q <= '0; bitCnt <= '0; byteCnt <= '0;
      divCnt <= '0; errFlag <= 1'b0; sclDrvLow <= 1'b0; sdaDrvLow <= 1'b0;
    end else begin
      divCnt <= (state == S_IDLE || tick) ? 16'd0 : divCnt + 16'd1;
      if (state == S_IDLE) begin
        if (startReq) begin
          state <= S_START; step <= STEP_SEGDEV; q <= '0;
          errFlag <= 1'b0; byteCnt <= '0;
        end
      end else if (tick) begin
        q <= q + 2'd1;
        case (state)
          S_START: case (q)
            2'd0: sdaDrvLow <= 1'b0;
            2'd1: sclDrvLow <= 1'b0;
            2'd2: sdaDrvLow <= 1'b1;
            default: begin
              sclDrvLow <= 1'b1; state <= S_BIT; bitCnt <= '0; step <= ctl.txSel;
            end
          endcase
          S_BIT: case (q)
            2'd0: if (!ackSlot) sdaDrvLow <= isData ? 1'b0 : !txMsb;
                  else sdaDrvLow <= isData && (byteCnt != LAST);
            2'd1: sclDrvLow <= 1'b0;
            2'd2: if (ackSlot && !isData && sdaIn) errFlag <= 1'b1;
            default: begin
              sclDrvLow <= 1'b1;
              if (!ackSlot) bitCnt <= bitCnt + 4'd1;
              else begin
                bitCnt <= '0;
                if (isData) begin
                  if (byteCnt == LAST) state <= S_STOP;
                  else byteCnt <= byteCnt + 1'b1;
                end else if (errFlag) state <= S_STOP;
                else if (step == STEP_SEG || step == STEP_OFF) begin
                  state <= S_START; step <= nextStep(step);
                end else step <= nextStep(step);
              end
            end
          endcase
          default: case (q)
            2'd0: sdaDrvLow <= 1'b1;
            2'd1: sclDrvLow <= 1'b0;
            2'd2: sdaDrvLow <= 1'b0;
            default: state <= S_IDLE;
          endcase
        endcase
      end
    end
  end

  // R2
  sda_only_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BIT && $past(state) == S_BIT && !sclDrvLow && !$past(sclDrvLow))
      |-> $stable(sdaDrvLow));
  // R11
  idle_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> (!sclDrvLow && !sdaDrvLow));
endmodule

// File: rtl/ddc_edid_reader.sv
module ddc_edid_reader
  import ddc_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq,
  output logic       sclDrvLow,
  output logic       sdaDrvLow,
  input  logic       sdaIn
);
  ddcCtlS      ctl;
  logic        busy, startReq, segZero, txMsb;
  logic [15:0] divVal;

  ddc_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy), .sdaIn(sdaIn),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .startReq(startReq), .segZero(segZero),
    .txMsb(txMsb), .divVal(divVal)
  );

  ddc_control #(.BYTES(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .segZero(segZero),
    .txMsb(txMsb), .sdaIn(sdaIn), .divVal(divVal), .ctl(ctl), .busy(busy),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow)
  );
endmodule

// File: tb/tb_ddc_edid_reader.sv
module tb_ddc_edid_reader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0, regRe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWdata = 8'd0, regRdata;
  logic irq, sclDrvLow, sdaDrvLow, sdaInW;
  logic slvLow = 1'b0;
  logic sclLine, sdaLine;

  int checks = 0, fails = 0, cyc = 0;
  int segHits = 0, bytesSent = 0, nackAt = -1, riseCnt = 0;
  int riseCyc [16];
  bit segAckEn = 1'b0;
  logic [7:0] expQ [$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sclLine = ~sclDrvLow;
  assign sdaLine = ~(sdaDrvLow | slvLow);
  assign sdaInW  = sdaLine;

  ddc_edid_reader dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow), .sdaIn(sdaInW)
  );

  function automatic logic [7:0] edidByte(int s, int a);
    return 8'((s * 37) + ((a & 255) * 5) + 3);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; regRe = 1'b1; #2 v = regRdata;
    @(negedge clk); regRe = 1'b0;
  endtask

  // driver: expected FIFO contents in host read order
  task automatic expectBlock(input int seg, input int off, input int startSlot);
    for (int k = 0; k < 128; k++) expQ.push_back(edidByte(seg, off + ((k - startSlot) & 127)));
  endtask

  // monitor: pop and compare as the design delivers bytes
  task automatic drainFifo(input bit probeOther);
    logic [7:0] v, e;
    int n = 0;
    while (expQ.size() > 0) begin
      rd(3'd7, v);
      e = expQ.pop_front();
      check("R5/R10 fifo byte", v, e);
      n++;
      if (probeOther && (n % 32 == 0)) begin
        rd(3'd0, v);  // must not advance the read pointer
        check("R10 other read", v, 3);
      end
    end
  endtask

  task automatic startXfer(input int seg, input int off, input int startSlot);
    segHits = 0; bytesSent = 0; nackAt = -1; riseCnt = 0;
    wr(3'd2, 8'(startSlot)); wr(3'd3, 8'(off)); wr(3'd4, 8'(seg));
  endtask

  task automatic waitDone(output logic [7:0] st);
    int t = 0;
    st = 8'd0;
    while (!st[0] && t < 40000) begin rd(3'd6, st); t++; end
    if (!st[0]) check("R6 completion timeout", 0, 1);
  endtask

  // display model on the wired bus
  initial begin
    int cnt, ph;
    logic [7:0] sh, rb, ptr, curSeg;
    logic pScl, pSda, mNack;
    cnt = 0; ph = 0; sh = 0; rb = 0; ptr = 0; curSeg = 0; pScl = 1; pSda = 1; mNack = 0;
    forever begin
      @(negedge clk);
      if (pScl && sclLine && pSda && !sdaLine) begin
        ph = 1; cnt = -1; mNack = 0; slvLow = 1'b0;
      end else if (pScl && sclLine && !pSda && sdaLine) begin
        ph = 0; slvLow = 1'b0; curSeg = 0;
      end else if (!pScl && sclLine) begin
        if (riseCnt < 16) riseCyc[riseCnt] = cyc;
        riseCnt++;
        if (ph >= 1 && ph <= 3 && cnt >= 0 && cnt < 8) sh = {sh[6:0], sdaLine};
        if (ph == 4 && cnt == 8 && sdaLine) begin mNack = 1; nackAt = bytesSent; end
      end else if (pScl && !sclLine) begin
        cnt++;
        if (cnt == 8) begin
          case (ph)
            1: if (sh == 8'h60) begin
                 segHits++;
                 if (segAckEn) begin slvLow = 1'b1; ph = 2; end else ph = 5;
               end else if (sh == 8'hA0) begin slvLow = 1'b1; ph = 3; end
               else if (sh == 8'hA1) begin slvLow = 1'b1; ph = 6; end
               else ph = 5;
            2: begin curSeg = sh; slvLow = 1'b1; ph = 5; end
            3: begin ptr = sh; slvLow = 1'b1; ph = 5; end
            4: slvLow = 1'b0;
            default: ;
          endcase
        end else if (cnt == 9) begin
          cnt = 0; slvLow = 1'b0;
          if (ph == 6 || (ph == 4 && !mNack)) begin
            rb = edidByte(curSeg, ptr); ptr++; bytesSent++; slvLow = ~rb[7]; ph = 4;
          end else if (ph == 4) ph = 5;
        end else if (ph == 4 && cnt < 8) slvLow = ~rb[7 - cnt];
      end
      pScl = sclLine; pSda = sdaLine;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 scl released", sclDrvLow, 0);
    check("R1 sda released", sdaDrvLow, 0);
    check("R1 irq", irq, 0);
    for (int a = 0; a < 7; a++) begin rd(3'(a), v); check("R1 reg reset", v, 0); end

    // transfer A: segment 0, offset 0, start slot 0, divider 2
    wr(3'd0, 8'd2); wr(3'd5, 8'd1);
    rd(3'd0, v); check("R1 divider readback", v, 2);
    segAckEn = 1'b0;
    startXfer(0, 0, 0);
    waitDone(v);
    check("R6 done only", v, 1);
    check("R6 irq with mask", irq, 1);
    check("R3 segment phase skipped", segHits, 0);
    check("R4 bytes sent", bytesSent, 128);
    check("R4 nack on last", nackAt, 128);
    check("R8 scl period div2", riseCyc[11] - riseCyc[10], 8);
    check("R11 lines released", {sclDrvLow, sdaDrvLow}, 0);
    expectBlock(0, 0, 0);
    drainFifo(1'b0);

    // R7 write-one-to-clear
    wr(3'd6, 8'd0); rd(3'd6, v); check("R7 write zero keeps", v, 1);
    wr(3'd6, 8'd1); rd(3'd6, v); check("R7 write one clears", v, 0);
    check("R6 irq drops", irq, 0);

    // transfer B: segment 1, upper half, start slot 5, divider 3, busy writes
    wr(3'd0, 8'd3);
    segAckEn = 1'b1;
    startXfer(1, 8'h80, 5);
    repeat (200) @(negedge clk);
    wr(3'd4, 8'd7);  // R9 must be ignored
    wr(3'd0, 8'd9);  // R9 must be ignored
    waitDone(v);
    check("R6 done seg1", v, 1);
    check("R3 segment phase sent", segHits, 1);
    check("R4 bytes sent seg1", bytesSent, 128);
    check("R8 scl period div3", riseCyc[11] - riseCyc[10], 12);
    rd(3'd4, v); check("R9 segment held", v, 1);
    rd(3'd0, v); check("R9 divider held", v, 3);
    expectBlock(1, 8'h80, 5);
    drainFifo(1'b1);
    wr(3'd6, 8'd3);

    // transfer C: refused segment address, interrupt masked
    wr(3'd5, 8'd0);
    segAckEn = 1'b0;
    startXfer(2, 0, 0);
    waitDone(v);
    check("R11 done and error", v, 3);
    check("R6 masked irq", irq, 0);
    check("R11 no data read", bytesSent, 0);
    check("R11 lines released", {sclDrvLow, sdaDrvLow}, 0);
    wr(3'd6, 8'd2); rd(3'd6, v); check("R7 error bit cleared alone", v, 1);
    wr(3'd6, 8'd1);

    // transfer D: divider 0 acts as 1, start via R2
    wr(3'd0, 8'd0); wr(3'd5, 8'd1);
    startXfer(0, 8'h80, 0);
    waitDone(v);
    check("R2 transfer started", v, 1);
    check("R8 scl period div0", riseCyc[11] - riseCyc[10], 4);
    check("R6 irq set", irq, 1);
    expectBlock(0, 8'h80, 0);
    drainFifo(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule